// File: doc/BRIEF.md
# Timer Compare Output Pin Unit

This block keeps the one-bit compare state of an 8-bit timer and decides what a shared general-purpose I/O pin shows. The timer supplies a compare-match strobe, a force strobe, its waveform mode, its count direction and a bottom-of-count indication. A two-bit output-action field is written by software through `mode_wr`/`mode_wdata`. This field has two roles. It selects how the compare state reacts to timer events. When it is non-zero, it also replaces the port data bit on the pin with the compare state.

The action field has no shadow copy. A write is used from the clock edge that stores it. The direction of the pin is always set by the port's direction bit, so software can preload the compare state with a force strobe while the pin is still an input. The pin then shows a known level as soon as it is turned into an output.

Top module: `tcmp_pin_unit`

## Requirements
- R1: A write on `mode_wr` stores `mode_wdata` at that clock edge. The new field controls the pin source and the event actions from the next cycle on.
- R2: While the action field is non-zero, `pin_out` equals `cmp_state`. While it is 00, `pin_out` equals `port_data`.
- R3: `pin_oe` equals `port_dir` at all times, whatever the action field is.
- R4: The pin override of R2 applies in every waveform mode. The `wave_mode` encoding is 00 normal, 01 CTC, 10 fast PWM, 11 phase-correct PWM.
- R5: `cmp_state` can be loaded by a force strobe while `port_dir` is 0. When `port_dir` is set, the loaded level appears on the pin.
- R6: With the action field at 00, no match, bottom or force event changes `cmp_state`, in any waveform mode.
- R7: In normal (00) and CTC (01) waveform modes, a match or a force strobe applies one action, chosen by the field. Field 01 toggles `cmp_state`, 10 clears it and 11 sets it.
- R8: In fast PWM (10), field 10 clears `cmp_state` on a match and sets it on `at_bottom`. Field 11 does the opposite. When a match and bottom arrive in the same cycle, the match action wins.
- R9: In fast PWM, field 01 causes no change. In both PWM waveform modes (10, 11) the force strobe causes no change.
- R10: In phase-correct PWM (11), field 10 clears `cmp_state` on a match while counting up (`count_down`=0) and sets it on a match while counting down. Field 11 does the opposite, and field 01 causes no change.
- R11: A synchronous active-low reset clears `cmp_state` and the action field, so the pin follows `port_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Write strobe for the action field |
| mode_wdata | input | 2 | New action field value |
| wave_mode | input | 2 | Timer waveform mode |
| match | input | 1 | Compare-match strobe |
| force_cmp | input | 1 | Force-compare strobe |
| count_down | input | 1 | Counter is counting down |
| at_bottom | input | 1 | Counter is at bottom |
| port_data | input | 1 | Port data bit of the pin |
| port_dir | input | 1 | Port direction bit (1 = output) |
| cmp_state | output | 1 | Internal compare state |
| pin_out | output | 1 | Value presented to the pad |
| pin_oe | output | 1 | Pad output enable |

## Verification
The assertions take the timer strobes to be single-cycle pulses that are valid for the cycle in which they are high. They also assume the event checks are only meaningful while `wave_mode` does not change in that same cycle. The bench drives every input on the falling edge, holds `wave_mode` fixed around each strobe and clears each strobe after one cycle. It reads the results on the next falling edge, so each strobe meets exactly one rising edge.

// File: rtl/tcmp_pkg.sv
// Shared types for the timer compare output pin unit.
package tcmp_pkg;
    typedef enum logic [1:0] {
        WAVE_NORMAL = 2'b00,
        WAVE_CTC    = 2'b01,
        WAVE_FAST   = 2'b10,
        WAVE_PHASE  = 2'b11
    } wave_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } act_e;
endpackage

// File: rtl/tcmp_mode_reg.sv
// Output-action field register. Single copy, no shadow: a write is
// visible from the edge that stores it. Assumes sync active-low reset.
module tcmp_mode_reg #(
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [MODE_W-1:0] wdata,
    output logic [MODE_W-1:0] mode
);
    // Store the field on a write; reset returns it to no action.
    always_ff @(posedge clk) begin
        if (!rst_n)  mode <= '0;
        else if (wr) mode <= wdata;
    end

    // R1
    mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (mode == $past(wdata)));

    // R11
    mode_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (mode == '0));
endmodule

// File: rtl/tcmp_state_logic.sv
// Compare state register. Decodes the action for the current waveform
// mode and timer events, then applies it. Assumes match/force/bottom
// are one-cycle strobes qualified by wave_mode in the same cycle.
module tcmp_state_logic
    import tcmp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic [1:0] wave_mode,
    input  logic       match,
    input  logic       force_cmp,
    input  logic       count_down,
    input  logic       at_bottom,
    output logic       state
);
    wave_e wave;
    act_e  act;
    logic  state_nx;

    assign wave = wave_e'(wave_mode);

    // Choose the action the current events call for.
    always_comb begin
        act = ACT_NONE;
        unique case (wave)
            WAVE_NORMAL, WAVE_CTC: begin
                if (match || force_cmp) act = act_e'(mode);
            end
            WAVE_FAST: begin
                if (match) begin
                    if (mode == 2'b10)      act = ACT_CLEAR;
                    else if (mode == 2'b11) act = ACT_SET;
                end else if (at_bottom) begin
                    if (mode == 2'b10)      act = ACT_SET;
                    else if (mode == 2'b11) act = ACT_CLEAR;
                end
            end
            WAVE_PHASE: begin
                if (match) begin
                    if (mode == 2'b10)      act = count_down ? ACT_SET : ACT_CLEAR;
                    else if (mode == 2'b11) act = count_down ? ACT_CLEAR : ACT_SET;
                end
            end
            default: act = ACT_NONE;
        endcase
    end

    // Apply the selected action to the current state.
    always_comb begin
        unique case (act)
            ACT_TOGGLE: state_nx = ~state;
            ACT_CLEAR:  state_nx = 1'b0;
            ACT_SET:    state_nx = 1'b1;
            default:    state_nx = state;
        endcase
    end

    // Hold the compare state; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= 1'b0;
        else        state <= state_nx;
    end

    // R6
    idle_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> $stable(state));

    // R7
    toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_mode[1] == 1'b0 && match && mode == 2'b01) |=> (state != $past(state)));

    // R8
    fast_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_mode == 2'b10 && at_bottom && !match && mode == 2'b10) |=> state);

    // R9
    pwm_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_mode[1] && force_cmp && !match && !at_bottom) |=> $stable(state));

    // R10
    phase_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_mode == 2'b11 && match && !count_down && mode == 2'b10) |=> !state);

    // R11
    state_reset_chk: assert property (@(posedge clk)
        !rst_n |=> !state);
endmodule

// File: rtl/tcmp_pin_mux.sv
// Pin source selection. A non-zero action field substitutes the compare
// state for the port data bit; direction always comes from the port.
module tcmp_pin_mux #(
    parameter int MODE_W = 2
) (
    input  logic [MODE_W-1:0] mode,
    input  logic              cmp_state,
    input  logic              port_data,
    input  logic              port_dir,
    output logic              pin_out,
    output logic              pin_oe
);
    logic override;

    // Select the pin value and pass the direction through.
    always_comb begin
        override = |mode;
        pin_out  = override ? cmp_state : port_data;
        pin_oe   = port_dir;
    end
endmodule

// File: rtl/tcmp_pin_unit.sv
// Top of the timer compare output pin unit: action field register,
// compare state logic and pin source mux. Assumes timer strobes are
// single-cycle and synchronous to clk; sync active-low reset.
module tcmp_pin_unit #(
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic [1:0]        wave_mode,
    input  logic              match,
    input  logic              force_cmp,
    input  logic              count_down,
    input  logic              at_bottom,
    input  logic              port_data,
    input  logic              port_dir,
    output logic              cmp_state,
    output logic              pin_out,
    output logic              pin_oe
);
    logic [MODE_W-1:0] mode_q;

    tcmp_mode_reg #(.MODE_W(MODE_W)) mode_reg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (mode_wr),
        .wdata (mode_wdata),
        .mode  (mode_q)
    );

    tcmp_state_logic state_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_q[1:0]),
        .wave_mode  (wave_mode),
        .match      (match),
        .force_cmp  (force_cmp),
        .count_down (count_down),
        .at_bottom  (at_bottom),
        .state      (cmp_state)
    );

    tcmp_pin_mux #(.MODE_W(MODE_W)) mux_i (
        .mode      (mode_q),
        .cmp_state (cmp_state),
        .port_data (port_data),
        .port_dir  (port_dir),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    // R2
    pin_follows_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_wr) && $past(mode_wdata) != '0) |-> (pin_out == cmp_state));

    // R3
    dir_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(port_dir) |-> $stable(pin_oe));
endmodule

// File: tb/tcmp_pin_unit_tb.sv
module tcmp_pin_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode_wr, match, force_cmp, count_down, at_bottom;
    logic       port_data, port_dir;
    logic [1:0] mode_wdata, wave_mode;
    logic       cmp_state, pin_out, pin_oe;
    int         n_chk  = 0;
    int         n_fail = 0;

    always #4 clk = ~clk;  // 125 MHz

    tcmp_pin_unit dut_i (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .wave_mode(wave_mode), .match(match), .force_cmp(force_cmp),
        .count_down(count_down), .at_bottom(at_bottom), .port_data(port_data),
        .port_dir(port_dir), .cmp_state(cmp_state), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // One cycle: strobes set on a falling edge, cleared on the next one.
    task automatic ev(input logic m, input logic f, input logic b, input logic d);
        match = m; force_cmp = f; at_bottom = b; count_down = d;
        @(negedge clk);
        match = 0; force_cmp = 0; at_bottom = 0;
    endtask

    task automatic set_mode(input logic [1:0] v);
        mode_wr = 1; mode_wdata = v;
        @(negedge clk);
        mode_wr = 0;
    endtask

    // Put the state at a known level using normal-mode force.
    task automatic load_state(input logic v);
        wave_mode = 2'b00;
        set_mode(v ? 2'b11 : 2'b10);
        ev(0, 1, 0, 0);
    endtask

    task automatic do_reset();
        rst_n = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
    endtask

    task automatic t_reset();
        port_data = 1; port_dir = 1;
        do_reset();
        chk("R11 state", cmp_state, 0);
        chk("R11 pin", pin_out, 1);
        load_state(1);
        port_data = 0;
        do_reset();
        chk("R11 state after run", cmp_state, 0);
        chk("R11 pin after run", pin_out, 0);
    endtask

    task automatic t_write_timing();
        do_reset();
        port_data = 1;
        mode_wr = 1; mode_wdata = 2'b01;
        #1 chk("R1 before edge", pin_out, 1);
        @(negedge clk);
        mode_wr = 0;
        chk("R1 after edge", pin_out, 0);
    endtask

    task automatic t_override();
        load_state(1);
        port_data = 0;
        chk("R2 override", pin_out, 1);
        set_mode(2'b00);
        chk("R2 port", pin_out, 0);
        port_data = 1; #1;
        chk("R2 port follow", pin_out, 1);
    endtask

    task automatic t_dir();
        set_mode(2'b11);
        port_dir = 0; #1;
        chk("R3 oe low", pin_oe, 0);
        port_dir = 1; #1;
        chk("R3 oe high", pin_oe, 1);
    endtask

    task automatic t_wave_indep();
        load_state(1);
        port_data = 0;
        for (int w = 0; w < 4; w++) begin
            wave_mode = w[1:0]; #1;
            chk("R4 override per wave", pin_out, 1);
        end
    endtask

    task automatic t_preload();
        port_dir = 0; port_data = 0;
        wave_mode = 2'b00;
        set_mode(2'b11);
        ev(0, 1, 0, 0);
        chk("R5 loaded", cmp_state, 1);
        chk("R5 not driving", pin_oe, 0);
        port_dir = 1; #1;
        chk("R5 driving", pin_oe, 1);
        chk("R5 level", pin_out, 1);
    endtask

    task automatic t_idle_field();
        load_state(1);
        set_mode(2'b00);
        for (int w = 0; w < 4; w++) begin
            wave_mode = w[1:0];
            ev(1, 1, 1, 0);
            ev(1, 0, 0, 1);
            chk("R6 no change", cmp_state, 1);
        end
    endtask

    task automatic t_nonpwm();
        load_state(1);
        wave_mode = 2'b00; set_mode(2'b01);
        ev(1, 0, 0, 0); chk("R7 toggle to 0", cmp_state, 0);
        ev(1, 0, 0, 0); chk("R7 toggle to 1", cmp_state, 1);
        ev(1, 1, 0, 0); chk("R7 single toggle", cmp_state, 0);
        wave_mode = 2'b01; set_mode(2'b11);
        ev(1, 0, 0, 0); chk("R7 ctc set", cmp_state, 1);
        set_mode(2'b10);
        ev(0, 1, 0, 0); chk("R7 force clear", cmp_state, 0);
        set_mode(2'b01);
        ev(0, 1, 0, 0); chk("R7 force toggle", cmp_state, 1);
    endtask

    task automatic t_fast();
        load_state(0);
        wave_mode = 2'b10; set_mode(2'b10);
        ev(0, 0, 1, 0); chk("R8 bottom set", cmp_state, 1);
        ev(1, 0, 0, 0); chk("R8 match clear", cmp_state, 0);
        ev(0, 0, 1, 0);
        ev(1, 0, 1, 0); chk("R8 match wins", cmp_state, 0);
        set_mode(2'b11);
        ev(1, 0, 0, 0); chk("R8 inv match set", cmp_state, 1);
        ev(0, 0, 1, 0); chk("R8 inv bottom clear", cmp_state, 0);
    endtask

    task automatic t_reserved_force();
        load_state(1);
        wave_mode = 2'b10; set_mode(2'b01);
        ev(1, 0, 0, 0); ev(0, 0, 1, 0);
        chk("R9 fast 01", cmp_state, 1);
        set_mode(2'b10);
        ev(0, 1, 0, 0); chk("R9 fast force", cmp_state, 1);
        wave_mode = 2'b11;
        ev(0, 1, 0, 0); chk("R9 phase force", cmp_state, 1);
    endtask

    task automatic t_phase();
        load_state(1);
        wave_mode = 2'b11; set_mode(2'b10);
        ev(1, 0, 0, 0); chk("R10 up clear", cmp_state, 0);
        ev(1, 0, 0, 1); chk("R10 down set", cmp_state, 1);
        ev(0, 0, 1, 0); chk("R10 bottom ignored", cmp_state, 1);
        set_mode(2'b11);
        ev(1, 0, 0, 1); chk("R10 inv down clear", cmp_state, 0);
        ev(1, 0, 0, 0); chk("R10 inv up set", cmp_state, 1);
        set_mode(2'b01);
        ev(1, 0, 0, 0); chk("R10 reserved", cmp_state, 1);
    endtask

    initial begin
        rst_n = 0; mode_wr = 0; mode_wdata = 0; wave_mode = 0;
        match = 0; force_cmp = 0; count_down = 0; at_bottom = 0;
        port_data = 0; port_dir = 0;
        @(negedge clk);
        t_reset();
        t_write_timing();
        t_override();
        t_dir();
        t_wave_indep();
        t_preload();
        t_idle_field();
        t_nonpwm();
        t_fast();
        t_reserved_force();
        t_phase();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule